// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is a single timer channel built around a 16-bit down counter. A parallel reload value, a mode and a count-format select are captured together on a load strobe. The working count then drops by one on every clock cycle where the channel tick enable is high, as long as the gate input is high. A single output line follows one of three waveforms: a one-shot that rises when the count expires, a rate generator with one tick of low output per period, and a square wave with an even or near-even duty cycle.

Counting is either plain binary or four-digit BCD. A loaded value of zero stands for the largest count the format can hold. The live count is always visible on a port, so a surrounding register file can snapshot it. Bus decoding and the other classic timer modes live outside this block.

Top module: `dcount_timer`

## Requirements
- R1: After reset the output line is high and the live count is 0. The count does not move on ticks until the first load.
- R2: On a cycle with `loadStb` high, the live count in the following cycle equals `loadVal`. A load wins over a tick in the same cycle, and counting resumes on the next tick.
- R3: In binary format (`bcdSel`=0), each cycle with `tickEn`=1 and `gateIn`=1 lowers the count by one. A cycle without a tick leaves the count unchanged.
- R4: In BCD format (`bcdSel`=1) each 4-bit digit counts 9 down to 0 and wraps to 9 with a borrow from the next digit, e.g. 0x1000 steps to 0x0999.
- R5: A loaded value of 0 means 65536 ticks in binary and 10000 ticks in BCD. The first tick after loading 0 gives 0xFFFF in binary and 0x9999 in BCD.
- R6: One-shot mode (`modeSel`=00): the output goes low in the cycle after the load. It goes high on the tick that takes the count from 1 to 0 and stays high until the next load. The count is not reloaded and keeps decrementing with wrap.
- R7: Rate mode (`modeSel`=10) with load value N≥2: the output goes low on the tick that brings the count to 1. The next tick reloads N and raises the output, so the output is low for one tick out of every N.
- R8: Square mode (`modeSel`=11) with load value N≥2: the output stays high for ceil(N/2) ticks and low for floor(N/2) ticks. The count reloads N at the end of each period.
- R9: With `gateIn`=0 the count holds in every mode. In rate and square modes the output is high in the cycle after gate is seen low.
- R10: `modeSel`=01 behaves as one-shot. Mode and format are captured only at a load, so changing `modeSel` or `bcdSel` while counting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Channel tick: one count step per clock with this high |
| gateIn | input | 1 | Count qualifier; low suspends counting |
| loadStb | input | 1 | Captures loadVal, modeSel and bcdSel |
| loadVal | input | 16 | Reload value (binary or BCD digits) |
| modeSel | input | 2 | 00/01 one-shot, 10 rate, 11 square |
| bcdSel | input | 1 | 1 selects BCD counting |
| outLine | output | 1 | Channel output waveform |
| liveCount | output | 16 | Current working count |

## Verification
A wrong count decrement or a missed BCD borrow shows on `liveCount` one cycle after the tick that caused it. A wrong half-period threshold or reload value shows on `outLine` within one period: the high or low run has the wrong length, or the next period starts from the wrong count. The live count and the output are compared with an integer reference every cycle, so a corrupted mode, format or reload register is reported at the first tick where its effect differs.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'b00,
    MODE_RATE    = 2'b10,
    MODE_SQUARE  = 2'b11
  } dctMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new reload value and count
    logic step;    // decrement the working count
    logic reload;  // restart the working count from the reload value
  } dctStrobe_t;

  // Select 01 has no mode of its own and falls back to one-shot
  function automatic dctMode_e decodeMode(input logic [1:0] sel);
    case (sel)
      2'b10:   decodeMode = MODE_RATE;
      2'b11:   decodeMode = MODE_SQUARE;
      default: decodeMode = MODE_ONESHOT;
    endcase
  endfunction

endpackage

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dctStrobe_t      strb,
  input  logic            bcdMode,
  input  logic [CntW-1:0] loadVal,
  output logic [CntW-1:0] count,
  output logic            cntIsOne,
  output logic            nextIsOne,
  output logic            nextIsHalf
);

  localparam int NumDig = CntW / 4;

  logic [CntW-1:0] countQ;
  logic [CntW-1:0] reloadQ;
  logic [CntW-1:0] binDec;
  logic [CntW-1:0] bcdDec;
  logic [CntW-1:0] decVal;
  logic [CntW-1:0] bcdHalf;
  logic [CntW-1:0] halfVal;

  assign binDec = countQ - 1'b1;

  // Per-digit BCD decrement and halving
  for (genvar g = 0; g < NumDig; g++) begin : g_dig
    logic [3:0] dig;
    logic [3:0] rdig;
    logic       dBorrow;
    logic       upOdd;

    assign dig  = countQ[4*g +: 4];
    assign rdig = reloadQ[4*g +: 4];

    if (g == 0) begin : g_lo
      assign dBorrow = 1'b1;
    end else begin : g_hi
      assign dBorrow = (countQ[4*g-1:0] == '0);
    end

    if (g == NumDig - 1) begin : g_top
      assign upOdd = 1'b0;
    end else begin : g_mid
      assign upOdd = reloadQ[4*(g+1)];
    end

    assign bcdDec[4*g +: 4]  = !dBorrow ? dig :
                               ((dig == 4'd0) ? 4'd9 : dig - 4'd1);
    assign bcdHalf[4*g +: 4] = {1'b0, rdig[3:1]} + (upOdd ? 4'd5 : 4'd0);
  end

  assign decVal = bcdMode ? bcdDec : binDec;

  always_comb begin
    if (reloadQ == '0) begin
      halfVal = bcdMode ? {4'h5, {(CntW-4){1'b0}}} : {1'b1, {(CntW-1){1'b0}}};
    end else begin
      halfVal = bcdMode ? bcdHalf : (reloadQ >> 1);
    end
  end

  assign cntIsOne   = (countQ == CntW'(1));
  assign nextIsOne  = (decVal == CntW'(1));
  assign nextIsHalf = (decVal == halfVal);
  assign count      = countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      reloadQ <= '0;
    end else if (strb.load) begin
      countQ  <= loadVal;
      reloadQ <= loadVal;
    end else if (strb.reload) begin
      countQ  <= reloadQ;
    end else if (strb.step) begin
      countQ  <= decVal;
    end
  end

endmodule

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       gateIn,
  input  logic       loadStb,
  input  logic [1:0] modeSel,
  input  logic       bcdSel,
  input  logic       cntIsOne,
  input  logic       nextIsOne,
  input  logic       nextIsHalf,
  output dctStrobe_t strb,
  output logic       bcdMode,
  output logic       outLine,
  output dctMode_e   modeCur,
  output logic       runCur
);

  dctMode_e modeQ;
  logic     bcdQ;
  logic     runQ;
  logic     outQ;
  logic     outNext;
  logic     periodic;
  logic     tickOk;

  assign periodic = (modeQ != MODE_ONESHOT);
  assign tickOk   = runQ && tickEn && gateIn && !loadStb;

  always_comb begin
    strb        = '0;
    strb.load   = loadStb;
    strb.reload = tickOk && periodic && cntIsOne;
    strb.step   = tickOk && !(periodic && cntIsOne);
  end

  always_comb begin
    outNext = outQ;
    if (loadStb) begin
      outNext = (decodeMode(modeSel) != MODE_ONESHOT);
    end else if (runQ && periodic && !gateIn) begin
      outNext = 1'b1;
    end else if (tickOk) begin
      case (modeQ)
        MODE_ONESHOT: if (cntIsOne) outNext = 1'b1;
        MODE_RATE:    outNext = cntIsOne || !nextIsOne;
        MODE_SQUARE: begin
          if (cntIsOne)        outNext = 1'b1;
          else if (nextIsHalf) outNext = 1'b0;
        end
        default: outNext = outQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_ONESHOT;
      bcdQ  <= 1'b0;
      runQ  <= 1'b0;
      outQ  <= 1'b1;
    end else begin
      if (loadStb) begin
        modeQ <= decodeMode(modeSel);
        bcdQ  <= bcdSel;
        runQ  <= 1'b1;
      end
      outQ <= outNext;
    end
  end

  assign bcdMode = bcdQ;
  assign outLine = outQ;
  assign modeCur = modeQ;
  assign runCur  = runQ;

endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import dct_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tickEn,
  input  logic            gateIn,
  input  logic            loadStb,
  input  logic [CntW-1:0] loadVal,
  input  logic [1:0]      modeSel,
  input  logic            bcdSel,
  output logic            outLine,
  output logic [CntW-1:0] liveCount
);

  dctStrobe_t strb;
  logic       bcdMode;
  logic       cntIsOne;
  logic       nextIsOne;
  logic       nextIsHalf;
  dctMode_e   modeCur;
  logic       runCur;

  dct_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .gateIn     (gateIn),
    .loadStb    (loadStb),
    .modeSel    (modeSel),
    .bcdSel     (bcdSel),
    .cntIsOne   (cntIsOne),
    .nextIsOne  (nextIsOne),
    .nextIsHalf (nextIsHalf),
    .strb       (strb),
    .bcdMode    (bcdMode),
    .outLine    (outLine),
    .modeCur    (modeCur),
    .runCur     (runCur)
  );

  dct_datapath #(.CntW(CntW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .bcdMode    (bcdMode),
    .loadVal    (loadVal),
    .count      (liveCount),
    .cntIsOne   (cntIsOne),
    .nextIsOne  (nextIsOne),
    .nextIsHalf (nextIsHalf)
  );

endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
#(
  parameter int CntW = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            tickEn,
  input logic            gateIn,
  input logic            loadStb,
  input logic [CntW-1:0] loadVal,
  input logic [1:0]      modeSel,
  input logic [CntW-1:0] liveCount,
  input logic            outLine,
  input dctMode_e        modeCur,
  input logic            runCur
);

  // R2: a load shows up on the live count one cycle later
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (liveCount == $past(loadVal)));

  // R3: without a tick and without a load the count holds
  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !tickEn) |=> $stable(liveCount));

  // R9: gate low freezes the count
  p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !gateIn) |=> $stable(liveCount));

  // R9: gate low forces the output high in the periodic modes
  p_gate_out_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (runCur && !loadStb && !gateIn && modeCur != MODE_ONESHOT) |=> outLine);

  // R6: loading one-shot drives the output low
  p_oneshot_load_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && decodeMode(modeSel) == MODE_ONESHOT) |=> !outLine);

  // R6: once high in one-shot, the output stays high until a load
  p_oneshot_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur == MODE_ONESHOT && outLine && !loadStb) |=> outLine);

  // R7: in rate mode the output is low only while the count is 1
  p_rate_low_at_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur == MODE_RATE && !outLine) |-> (liveCount == CntW'(1)));

endmodule

bind dcount_timer dct_checker #(.CntW(CntW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .gateIn    (gateIn),
  .loadStb   (loadStb),
  .loadVal   (loadVal),
  .modeSel   (modeSel),
  .liveCount (liveCount),
  .outLine   (outLine),
  .modeCur   (modeCur),
  .runCur    (runCur)
);

// File: tb/sim_dcount_timer.sv
`timescale 1ns/1ps
module sim_dcount_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        gateIn = 1'b1;
  logic        loadStb = 1'b0;
  logic [15:0] loadVal = '0;
  logic [1:0]  modeSel = 2'b00;
  logic        bcdSel = 1'b0;
  logic        outLine;
  logic [15:0] liveCount;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit cmpOn = 0;

  // Reference state (integer ticks remaining)
  int mN = 0, mRem = 0, mMode = 0, mMax = 65536;
  bit mBcd = 0, mRun = 0, mOut = 1;

  always #10 clk = ~clk;

  dcount_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gateIn(gateIn),
    .loadStb(loadStb), .loadVal(loadVal), .modeSel(modeSel),
    .bcdSel(bcdSel), .outLine(outLine), .liveCount(liveCount)
  );

  function automatic logic [15:0] encodeCnt(input int v, input bit bcd);
    if (bcd)
      return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    return v[15:0];
  endfunction

  function automatic int decodeLoad(input logic [15:0] v, input bit bcd);
    if (bcd)
      return int'(v[15:12]) * 1000 + int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
    return int'(v);
  endfunction

  function automatic int selToMode(input logic [1:0] s);
    return (s == 2'b10) ? 2 : (s == 2'b11) ? 3 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mOut = 1; mRem = 0; mMode = 0; mBcd = 0; mMax = 65536; mN = 0;
    end else if (loadStb) begin
      mMode = selToMode(modeSel);
      mBcd  = bcdSel;
      mMax  = bcdSel ? 10000 : 65536;
      mN    = (loadVal == 0) ? mMax : decodeLoad(loadVal, bcdSel);
      mRem  = mN;
      mOut  = (mMode != 0);
      mRun  = 1;
    end else if (mRun) begin
      if (!gateIn && mMode != 0) begin
        mOut = 1;
      end else if (gateIn && tickEn) begin
        if (mMode == 0) begin
          if (mRem == 1) mOut = 1;
          mRem = (mRem == 0) ? mMax - 1 : mRem - 1;
        end else if (mRem == 1) begin
          mRem = mN;
          mOut = 1;
        end else begin
          mRem = mRem - 1;
          if (mMode == 2) mOut = (mRem != 1);
          else if (mRem == mN / 2) mOut = 0;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Called at each falling edge, before inputs change
  task automatic compareModel();
    string outReq;
    if (!cmpOn) return;
    outReq = (mMode == 0) ? "R6" : (mMode == 2) ? "R7" : "R8";
    check(mBcd ? "R4" : "R3", "count", int'(liveCount), int'(encodeCnt(mRem % mMax, mBcd)));
    check(outReq, "out", int'(outLine), int'(mOut));
  endtask

  task automatic cyc();
    @(negedge clk);
    compareModel();
  endtask

  task automatic doLoad(input logic [15:0] v, input logic [1:0] m, input bit b, input bit tk);
    loadStb = 1; loadVal = v; modeSel = m; bcdSel = b; tickEn = tk; gateIn = 1;
    cyc();
    loadStb = 0; tickEn = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1; gateIn = 1;
      cyc();
    end
    tickEn = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check("R1", "out after reset", int'(outLine), 1);
    check("R1", "count after reset", int'(liveCount), 0);
    tickEn = 1; gateIn = 1;
    repeat (3) @(negedge clk);
    check("R1", "count idle before load", int'(liveCount), 0);
    tickEn = 0;
    cmpOn = 1;

    // R2: load wins over a simultaneous tick
    doLoad(16'd5, 2'b00, 0, 1);
    check("R2", "loaded count", int'(liveCount), 5);
    check("R6", "out low after load", int'(outLine), 0);
    ticks(5);
    check("R6", "out high at zero", int'(outLine), 1);
    check("R6", "count at zero", int'(liveCount), 0);
    ticks(2);
    check("R6", "no reload, wraps", int'(liveCount), 16'hFFFE);

    // R4: BCD borrow across digits
    doLoad(16'h1000, 2'b00, 1, 0);
    ticks(1);
    check("R4", "bcd borrow", int'(liveCount), 16'h0999);

    // R5: zero load means maximum count
    doLoad(16'h0000, 2'b10, 0, 0);
    ticks(1);
    check("R5", "binary max", int'(liveCount), 16'hFFFF);
    doLoad(16'h0000, 2'b11, 1, 0);
    ticks(1);
    check("R5", "bcd max", int'(liveCount), 16'h9999);

    // R10: select 01 acts as one-shot
    doLoad(16'd3, 2'b01, 0, 0);
    check("R10", "sel 01 out low", int'(outLine), 0);

    // R10: mode change after load has no effect
    doLoad(16'd4, 2'b10, 0, 0);
    modeSel = 2'b00; bcdSel = 1;
    ticks(3);
    check("R10", "rate count kept", int'(liveCount), 1);
    check("R10", "rate out low at one", int'(outLine), 0);
    ticks(1);
    check("R7", "rate reload", int'(liveCount), 4);
    check("R7", "rate out high", int'(outLine), 1);

    // R9 and R8: gate low during square low phase
    doLoad(16'd6, 2'b11, 0, 0);
    ticks(3);
    check("R8", "square low at half", int'(outLine), 0);
    tickEn = 1; gateIn = 0;
    cyc();
    check("R9", "gate holds count", int'(liveCount), 3);
    check("R9", "gate forces high", int'(outLine), 1);
    gateIn = 1; tickEn = 0;

    // Random segments
    for (int s = 0; s < 40; s++) begin
      int n;
      logic [1:0] m;
      bit b;
      int tickPct, gatePct;
      n = 2 + int'($urandom % 30);
      m = 2'($urandom % 4);
      b = 1'($urandom % 2);
      tickPct = (s % 4 == 0) ? 100 : 40 + int'($urandom % 60);
      gatePct = (s % 3 == 0) ? 100 : 85;
      doLoad(encodeCnt(n, b), m, b, 1'($urandom % 2));
      for (int c = 0; c < 90; c++) begin
        tickEn = (int'($urandom % 100) < tickPct);
        gateIn = (int'($urandom % 100) < gatePct);
        modeSel = 2'($urandom % 4);
        bcdSel = 1'($urandom % 2);
        cyc();
      end
      tickEn = 0; gateIn = 1;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule